// File: doc/BRIEF.md
# Rank-Programmable Weighted Bit Counter

This block is a purely combinational counter that sums a set of single-bit operands and presents the total as an unsigned binary number. Each operand has its own configuration bit that gives it a weight of one (low rank) or two (high rank). A single counter circuit can therefore take on many different generalized-parallel-counter shapes, such as twelve doubled bits beside seven single bits, instead of one fixed count. A plain-count control forces every operand to low rank, which turns the block into an ordinary m-input, n-output ones counter.

The configuration is static. It is loaded before use and held while the operands change. Every operand counts towards the capacity of the output, so the largest possible total for a configuration is the operand count plus the number of high-rank operands. When that total could exceed the largest value the output can hold, the configuration is reported as illegal on a separate flag. In that case the count output is held at zero rather than showing a truncated sum. The block has no clock, no reset and no internal state.

Top module: `gpc_weighted_counter`

## Requirements
- R1: When `plain_i` is 1, `count_o` equals the number of 1s on `bits_i`, whatever `rank_hi_i` holds.
- R2: When `plain_i` is 0, an operand `bits_i[k]` contributes 2 to the total if `rank_hi_i[k]` is 1 and contributes 1 if `rank_hi_i[k]` is 0. `count_o` is the total in binary, with bit j carrying weight 2^j.
- R3: `overrun_o` is 1 exactly when N_IN plus the number of high-rank operands exceeds 2^N_OUT − 1. In plain mode no operand counts as high rank.
- R4: While `overrun_o` is 1, `count_o` is all zeros and never shows a truncated sum.
- R5: `overrun_o` depends only on `rank_hi_i` and `plain_i`. Changing `bits_i` alone never changes it.
- R6: `count_o` and `overrun_o` follow their inputs combinationally, in the same cycle, and an all-zero operand vector gives a count of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bits_i | input | N_IN | Operand bits to be counted |
| rank_hi_i | input | N_IN | Per-operand rank: 1 gives weight 2, 0 gives weight 1 |
| plain_i | input | 1 | 1 forces every operand to weight 1 |
| count_o | output | N_OUT | Weighted count in binary, or zero when the configuration is illegal |
| overrun_o | output | 1 | 1 when the configuration's largest possible total exceeds the output range |

## Verification
The bench builds two seven-operand instances, one with a four-bit output and one with a three-bit output, and drives them with the same stimulus. Seven operands keep every pairing of operand pattern and rank vector within reach, in both modes. The four-bit output is always legal, so its sweep covers every weighted sum. The three-bit output turns illegal as soon as any operand is high rank, so its sweep covers the overrun flag and the forced-zero output over every data pattern. A third instance with the default 19-operand, five-bit shape takes random configurations near the 31 boundary, including twelve versus thirteen high-rank operands.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

    // Width needed to hold any value from 0 to max_val inclusive
    function automatic int unsigned width_for(input int unsigned max_val);
        int unsigned w;
        w = 1;
        while ((64'(1) << w) <= 64'(max_val)) begin
            w = w + 1;
        end
        return w;
    endfunction

    // Largest unsigned value that fits in a field of the given width
    function automatic int unsigned field_max(input int unsigned width);
        return int'((64'(1) << width) - 64'(1));
    endfunction

endpackage

// File: rtl/gpc_rank_select.sv
module gpc_rank_select #(
    parameter int unsigned N_IN = 19
) (
    input  logic [N_IN-1:0] bits_i,
    input  logic [N_IN-1:0] rank_hi_i,
    input  logic            plain_i,
    output logic [N_IN-1:0] lo_bits_o,
    output logic [N_IN-1:0] hi_bits_o,
    output logic [N_IN-1:0] hi_mask_o
);

    // Effective rank mask: plain mode demotes every operand to weight 1
    assign hi_mask_o = plain_i ? '0 : rank_hi_i;

    for (genvar k = 0; k < N_IN; k++) begin : g_split
        assign hi_bits_o[k] = bits_i[k] & hi_mask_o[k];
        assign lo_bits_o[k] = bits_i[k] & ~hi_mask_o[k];
    end

endmodule

// File: rtl/gpc_popcount.sv
module gpc_popcount #(
    parameter int unsigned N_IN  = 19,
    parameter int unsigned CNT_W = 5
) (
    input  logic [N_IN-1:0]  vec_i,
    output logic [CNT_W-1:0] cnt_o
);

    // Running totals: stage k holds the count of vec_i[k-1:0]
    logic [CNT_W-1:0] stage [N_IN+1];

    assign stage[0] = '0;

    for (genvar k = 0; k < N_IN; k++) begin : g_acc
        assign stage[k+1] = stage[k] + CNT_W'(vec_i[k]);
    end

    assign cnt_o = stage[N_IN];

endmodule

// File: rtl/gpc_capacity_check.sv
module gpc_capacity_check
    import gpc_pkg::*;
#(
    parameter int unsigned N_IN  = 19,
    parameter int unsigned N_OUT = 5
) (
    input  logic [N_IN-1:0] hi_mask_i,
    output logic            overrun_o
);

    localparam int unsigned CNT_W = width_for(N_IN);
    localparam int unsigned LIMIT = field_max(N_OUT);

    logic [CNT_W-1:0] hi_cnt;

    gpc_popcount #(
        .N_IN (N_IN),
        .CNT_W(CNT_W)
    ) u_hi_cnt (
        .vec_i(hi_mask_i),
        .cnt_o(hi_cnt)
    );

    // Worst-case total: every operand at 1, high-rank ones counting twice
    assign overrun_o = (32'(N_IN) + 32'(hi_cnt)) > 32'(LIMIT);

endmodule

// File: rtl/gpc_weighted_counter.sv
module gpc_weighted_counter
    import gpc_pkg::*;
#(
    parameter int unsigned N_IN  = 19,
    parameter int unsigned N_OUT = 5
) (
    input  logic [N_IN-1:0]  bits_i,
    input  logic [N_IN-1:0]  rank_hi_i,
    input  logic             plain_i,
    output logic [N_OUT-1:0] count_o,
    output logic             overrun_o
);

    localparam int unsigned CNT_W = width_for(N_IN);
    localparam int unsigned SUM_W = width_for(2 * N_IN);
    localparam int unsigned EXT_W = (SUM_W > N_OUT) ? SUM_W : N_OUT;

    logic [N_IN-1:0]  lo_bits;
    logic [N_IN-1:0]  hi_bits;
    logic [N_IN-1:0]  hi_mask;
    logic [CNT_W-1:0] lo_cnt;
    logic [CNT_W-1:0] hi_cnt;
    logic [EXT_W-1:0] total;
    logic             cfg_bad;

    gpc_rank_select #(.N_IN(N_IN)) u_split (
        .bits_i   (bits_i),
        .rank_hi_i(rank_hi_i),
        .plain_i  (plain_i),
        .lo_bits_o(lo_bits),
        .hi_bits_o(hi_bits),
        .hi_mask_o(hi_mask)
    );

    gpc_popcount #(.N_IN(N_IN), .CNT_W(CNT_W)) u_lo_cnt (
        .vec_i(lo_bits),
        .cnt_o(lo_cnt)
    );

    gpc_popcount #(.N_IN(N_IN), .CNT_W(CNT_W)) u_hi_cnt (
        .vec_i(hi_bits),
        .cnt_o(hi_cnt)
    );

    gpc_capacity_check #(.N_IN(N_IN), .N_OUT(N_OUT)) u_cap (
        .hi_mask_i(hi_mask),
        .overrun_o(cfg_bad)
    );

    // Combine the two ranks: high-rank count shifted one place left
    assign total = EXT_W'(lo_cnt) + (EXT_W'(hi_cnt) << 1);

    always_comb begin
        overrun_o = cfg_bad;
        count_o   = cfg_bad ? '0 : total[N_OUT-1:0];
    end

endmodule

// File: rtl/gpc_counter_checker.sv
module gpc_counter_checker #(
    parameter int unsigned N_IN  = 19,
    parameter int unsigned N_OUT = 5
) (
    input logic [N_IN-1:0]  bits_i,
    input logic [N_IN-1:0]  rank_hi_i,
    input logic             plain_i,
    input logic [N_OUT-1:0] count_o,
    input logic             overrun_o
);

    localparam int unsigned LIMIT = (1 << N_OUT) - 1;

    always_comb begin
        if (!$isunknown({bits_i, rank_hi_i, plain_i, count_o, overrun_o})) begin
            // R1: a plain count never exceeds the number of set operands
            p_plain_bound_r1: assert (!plain_i || overrun_o ||
                                      32'(count_o) == 32'($countones(bits_i)));
            // R2: no set operand means nothing to count
            p_empty_zero_r2: assert (bits_i != '0 || count_o == '0);
            // R2: a weighted total is bounded by twice the set operands
            p_weight_bound_r2: assert (overrun_o ||
                                       32'(count_o) <= 32'(2 * $countones(bits_i)));
            // R3: a plain configuration that fits in the output is always legal
            p_plain_legal_r3: assert (!plain_i || N_IN > LIMIT || !overrun_o);
            // R3: with no high-rank operand the legality follows the operand count alone
            p_no_overflow_r3: assert (!(plain_i || rank_hi_i == '0) ||
                                      overrun_o == (N_IN > LIMIT));
            // R4: an illegal configuration yields a zero count
            p_zero_on_bad_r4: assert (!overrun_o || count_o == '0);
        end
    end

endmodule

bind gpc_weighted_counter gpc_counter_checker #(
    .N_IN (N_IN),
    .N_OUT(N_OUT)
) u_chk (
    .bits_i   (bits_i),
    .rank_hi_i(rank_hi_i),
    .plain_i  (plain_i),
    .count_o  (count_o),
    .overrun_o(overrun_o)
);

// File: tb/sim_gpc_weighted_counter.sv
`timescale 1ns/1ps
module sim_gpc_weighted_counter;

    localparam int unsigned SN = 7;
    localparam int unsigned BN = 19;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [SN-1:0] s_bits, s_rank;
    logic          s_plain;
    logic [3:0]    a_cnt;
    logic          a_bad;
    logic [2:0]    b_cnt;
    logic          b_bad;

    logic [BN-1:0] c_bits, c_rank;
    logic          c_plain;
    logic [4:0]    c_cnt;
    logic          c_bad;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    gpc_weighted_counter #(.N_IN(SN), .N_OUT(4)) u0 (
        .bits_i(s_bits), .rank_hi_i(s_rank), .plain_i(s_plain),
        .count_o(a_cnt), .overrun_o(a_bad)
    );

    gpc_weighted_counter #(.N_IN(SN), .N_OUT(3)) u1 (
        .bits_i(s_bits), .rank_hi_i(s_rank), .plain_i(s_plain),
        .count_o(b_cnt), .overrun_o(b_bad)
    );

    gpc_weighted_counter u2 (
        .bits_i(c_bits), .rank_hi_i(c_rank), .plain_i(c_plain),
        .count_o(c_cnt), .overrun_o(c_bad)
    );

    // Reference: weighted sum and legality computed from the requirements
    function automatic void ref_model(input logic [31:0] bits, input logic [31:0] rank,
                                      input logic plain, input int n, input int w,
                                      output int exp_cnt, output bit exp_bad);
        int sum = 0;
        int his = 0;
        for (int k = 0; k < n; k++) begin
            bit hi = !plain && rank[k];
            if (hi) his++;
            if (bits[k]) sum += hi ? 2 : 1;
        end
        exp_bad = (n + his) > ((1 << w) - 1);
        exp_cnt = exp_bad ? 0 : sum;
    endfunction

    task automatic check(input string tag, input int act_cnt, input bit act_bad,
                         input int exp_cnt, input bit exp_bad);
        vectors++;
        if (act_cnt != exp_cnt || act_bad != exp_bad) begin
            misses++;
            $display("FAIL %s: count=%0d overrun=%0b expected count=%0d overrun=%0b",
                     tag, act_cnt, act_bad, exp_cnt, exp_bad);
        end
    endtask

    function automatic string pick_tag(input logic plain, input bit bad);
        if (bad) return "R4/R3";
        if (plain) return "R1";
        return "R2";
    endfunction

    task automatic small_vec(input logic [SN-1:0] b, input logic [SN-1:0] r, input logic p);
        int  e;
        bit  eb;
        @(negedge clk);
        s_bits = b; s_rank = r; s_plain = p;
        #1;  // R6: sampled with no clock edge between drive and check
        ref_model(32'(b), 32'(r), p, SN, 4, e, eb);
        check({pick_tag(p, eb), " u0"}, int'(a_cnt), a_bad, e, eb);
        ref_model(32'(b), 32'(r), p, SN, 3, e, eb);
        check({pick_tag(p, eb), " u1"}, int'(b_cnt), b_bad, e, eb);
    endtask

    task automatic big_vec(input logic [BN-1:0] b, input logic [BN-1:0] r, input logic p);
        int e;
        bit eb;
        @(negedge clk);
        c_bits = b; c_rank = r; c_plain = p;
        #1;
        ref_model(32'(b), 32'(r), p, BN, 5, e, eb);
        check({pick_tag(p, eb), " u2"}, int'(c_cnt), c_bad, e, eb);
    endtask

    initial begin
        s_bits = '0; s_rank = '0; s_plain = 1'b0;
        c_bits = '0; c_rank = '0; c_plain = 1'b0;
        #1;
        // R6: all-zero operands give zero before any clock edge
        check("R6 zero u0", int'(a_cnt), a_bad, 0, 1'b0);
        check("R6 zero u2", int'(c_cnt), c_bad, 0, 1'b0);

        // R1, R2, R3, R4, R5: every rank vector against every data pattern, both modes
        for (int p = 0; p < 2; p++) begin
            for (int r = 0; r < (1 << SN); r++) begin
                for (int b = 0; b < (1 << SN); b++) begin
                    small_vec(SN'(b), SN'(r), p[0]);
                end
            end
        end

        // R3: boundary shapes, 12 high-rank bits legal, 13 illegal
        big_vec('1, BN'(19'h00FFF), 1'b0);
        big_vec('1, BN'(19'h01FFF), 1'b0);
        big_vec(BN'(19'h7F000), BN'(19'h01FFF), 1'b0);
        big_vec('1, '1, 1'b1);  // R1: plain mode ignores ranks

        // R5: fixed illegal configuration, data varied, flag must stay set
        for (int i = 0; i < 200; i++) begin
            big_vec(BN'($urandom), BN'(19'h7FFFF), 1'b0);
        end

        // R2, R3: random configurations with sparse and dense rank vectors
        for (int i = 0; i < 6000; i++) begin
            logic [BN-1:0] rr;
            rr = (i % 2 == 0) ? BN'($urandom & $urandom) : BN'($urandom);
            big_vec(BN'($urandom), rr, (i % 7 == 0));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            misses++;
            $display("FAIL watchdog: cycles=%0d expected completion before %0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule